// File: doc/BRIEF.md
# Cache Error Trap Router

This block sits between the memory hierarchy's error detectors and the processor's trap logic. Every cycle it receives up to `NUM_LANES` error events. Each event names an error class and the operation that caused it. The block decides which of four trap requests, if any, to raise:

- the fast ECC trap,
- the instruction access error trap,
- the data access error trap,
- the disrupting ECC trap.

The chosen trap depends on both the error class and the operation, and it is gated by three enable bits in a control register.

Independently of those enables, every recognised event sets a sticky bit in a status register. Software clears a status bit by writing 1 to it. The control register also holds two forced-check-value fields, for data and for tag. These fields are passed straight to the ECC encoder as an override value with a valid flag.

Software reaches both registers through a simple single-cycle word interface:

- Address 0 selects the control register.
- Address 1 selects the status register.
- Read data is combinational from the selected register.

Trap requests are registered. Each one is a single-cycle pulse in the cycle after the event.

Top module: `err_trap_router`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, all four trap outputs are 0 and all force outputs are 0.
- R2: The control register (reg_addr=0) keeps bit 0 (corrected enable), bit 1 (uncorrectable enable), bit 3 (fast enable) and bits 18:4. All other bits are write-ignored and read as 0.
- R3: frc_data_val is control bits 12:4, frc_data_vld is bit 13, frc_tag_val is bits 17:14, and frc_tag_vld is bit 18.
- R4: A local-cache corrected (class 0) or uncorrected (class 1) event raises trap_fast only if the fast enable is set and the operation is load (op 0), instruction fetch (op 1), atomic (op 2) or vector fetch (op 6).
- R5: An event whose operation is store merge (op 3), writeback (op 4) or copyout (op 5) never raises trap_fast.
- R6: With the uncorrectable enable set, bus data (class 2), tag (class 3), timeout (class 4) and bus error (class 5) events raise trap_iacc for op 1, trap_dacc for op 0 or op 2, and trap_disr for ops 3, 4 and 5. With the enable clear they raise nothing.
- R7: A vector fetch (op 6) is routed exactly like an instruction fetch.
- R8: A hardware-corrected bus event (class 6) raises trap_disr for any operation when the corrected enable is set, and raises nothing otherwise.
- R9: Each event with class code c in 0..6 sets status bit c, whatever the enables are. Class code 7 sets no status bit and raises no trap.
- R10: A status bit stays set until a write to reg_addr=1 carries a 1 in that bit position. Bits written 0 are unchanged. A new event in the same cycle as the clear leaves its bit set.
- R11: Each trap output is a one-cycle pulse in the cycle after the event. Events on different lanes in the same cycle each raise their own trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | NUM_LANES | Per-lane event present |
| evt_cls | input | 3*NUM_LANES | Per-lane error class code |
| evt_op | input | 3*NUM_LANES | Per-lane operation code |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data of the selected register |
| trap_fast | output | 1 | Fast ECC trap request |
| trap_iacc | output | 1 | Instruction access error trap request |
| trap_dacc | output | 1 | Data access error trap request |
| trap_disr | output | 1 | Disrupting ECC trap request |
| frc_data_val | output | 9 | Forced data check value |
| frc_data_vld | output | 1 | Forced data check value is in use |
| frc_tag_val | output | 4 | Forced tag check value |
| frc_tag_vld | output | 1 | Forced tag check value is in use |

## Verification
The assertions assume that event fields are only meaningful while their lane's valid bit is high. They also assume that a register write and an event never target the same status bit, except in the deliberate set-wins case. The stimulus drives all inputs on the falling edge, and it holds valid low between sweep points so that each trap pulse can be attributed to exactly one event. The sweep covers every class, operation and enable combination on lane 0. Directed cases then exercise simultaneous lanes, the invalid class code and a clear that collides with a new event.

// File: rtl/etr_pkg.sv
package etr_pkg;
    localparam int CLS_W     = 3;
    localparam int OP_W      = 3;
    localparam int NUM_CLS   = 7;
    localparam int NUM_TRAPS = 4;

    typedef enum logic [CLS_W-1:0] {
        CLS_CE_LOCAL = 3'd0,
        CLS_UE_LOCAL = 3'd1,
        CLS_UE_BDATA = 3'd2,
        CLS_UE_TAG   = 3'd3,
        CLS_TIMEOUT  = 3'd4,
        CLS_BUSERR   = 3'd5,
        CLS_CE_BUS   = 3'd6,
        CLS_NONE     = 3'd7
    } cls_e;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD   = 3'd0,
        OP_IFETCH = 3'd1,
        OP_ATOMIC = 3'd2,
        OP_MERGE  = 3'd3,
        OP_WBACK  = 3'd4,
        OP_COPY   = 3'd5,
        OP_VFETCH = 3'd6,
        OP_RSVD   = 3'd7
    } op_e;

    // trap vector bit positions
    localparam int T_DISR = 0;
    localparam int T_DACC = 1;
    localparam int T_IACC = 2;
    localparam int T_FAST = 3;

    // control register bit positions
    localparam int B_EN_CE   = 0;
    localparam int B_EN_NC   = 1;
    localparam int B_EN_FAST = 3;
    localparam int B_FD_LO   = 4;
    localparam int FD_W      = 9;
    localparam int B_FD_VLD  = B_FD_LO + FD_W;
    localparam int B_FT_LO   = B_FD_VLD + 1;
    localparam int FT_W      = 4;
    localparam int B_FT_VLD  = B_FT_LO + FT_W;
endpackage

// File: rtl/etr_lane_route.sv
module etr_lane_route
    import etr_pkg::*;
(
    input  logic                 vld,
    input  logic [CLS_W-1:0]     cls,
    input  logic [OP_W-1:0]      op,
    input  logic                 en_ce,
    input  logic                 en_nc,
    input  logic                 en_fast,
    output logic [NUM_TRAPS-1:0] req,
    output logic [NUM_CLS-1:0]   hit
);
    logic is_fetch, is_load, is_late;

    always_comb begin
        is_fetch = 1'b0;
        is_load  = 1'b0;
        is_late  = 1'b0;
        unique case (op_e'(op))
            OP_IFETCH, OP_VFETCH:     is_fetch = 1'b1;
            OP_LOAD, OP_ATOMIC:       is_load  = 1'b1;
            OP_MERGE, OP_WBACK, OP_COPY: is_late = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        req = '0;
        hit = '0;
        if (vld) begin
            unique case (cls_e'(cls))
                CLS_CE_LOCAL, CLS_UE_LOCAL: begin
                    hit[cls] = 1'b1;
                    req[T_FAST] = en_fast && (is_fetch || is_load);
                end
                CLS_UE_BDATA, CLS_UE_TAG, CLS_TIMEOUT, CLS_BUSERR: begin
                    hit[cls] = 1'b1;
                    req[T_IACC] = en_nc && is_fetch;
                    req[T_DACC] = en_nc && is_load;
                    req[T_DISR] = en_nc && is_late;
                end
                CLS_CE_BUS: begin
                    hit[cls] = 1'b1;
                    req[T_DISR] = en_ce;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/etr_cfg_reg.sv
module etr_cfg_reg
    import etr_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cfg_q
);
    localparam logic [REG_W-1:0] KEEP =
        (REG_W'(1) << B_EN_CE) | (REG_W'(1) << B_EN_NC) | (REG_W'(1) << B_EN_FAST) |
        (((REG_W'(1) << (B_FT_VLD + 1)) - 1) & ~((REG_W'(1) << B_FD_LO) - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  cfg_q <= '0;
        else if (wr) cfg_q <= wdata & KEEP;
    end
endmodule

// File: rtl/etr_status_reg.sv
module etr_status_reg
    import etr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_en,
    input  logic [NUM_CLS-1:0] clr_bits,
    input  logic [NUM_CLS-1:0] set_bits,
    output logic [NUM_CLS-1:0] sts_q
);
    logic [NUM_CLS-1:0] clr_mask;

    always_comb clr_mask = clr_en ? clr_bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~clr_mask) | set_bits;
    end
endmodule

// File: rtl/err_trap_router.sv
module err_trap_router
    import etr_pkg::*;
#(
    parameter int NUM_LANES = 2,
    parameter int REG_W     = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LANES-1:0]       evt_valid,
    input  logic [CLS_W*NUM_LANES-1:0] evt_cls,
    input  logic [OP_W*NUM_LANES-1:0]  evt_op,
    input  logic                       reg_wr,
    input  logic                       reg_addr,
    input  logic [REG_W-1:0]           reg_wdata,
    output logic [REG_W-1:0]           reg_rdata,
    output logic                       trap_fast,
    output logic                       trap_iacc,
    output logic                       trap_dacc,
    output logic                       trap_disr,
    output logic [FD_W-1:0]            frc_data_val,
    output logic                       frc_data_vld,
    output logic [FT_W-1:0]            frc_tag_val,
    output logic                       frc_tag_vld
);
    localparam int PAD_W = REG_W - NUM_CLS;

    logic [REG_W-1:0]     cfg_q;
    logic [NUM_CLS-1:0]   sts_q;
    logic [NUM_TRAPS-1:0] lane_req [NUM_LANES];
    logic [NUM_CLS-1:0]   lane_hit [NUM_LANES];
    logic [NUM_TRAPS-1:0] req_any;
    logic [NUM_CLS-1:0]   hit_any;
    logic [NUM_TRAPS-1:0] trap_q;

    etr_cfg_reg #(.REG_W(REG_W)) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr && !reg_addr),
        .wdata (reg_wdata),
        .cfg_q (cfg_q)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        etr_lane_route route_i (
            .vld     (evt_valid[g]),
            .cls     (evt_cls[g*CLS_W +: CLS_W]),
            .op      (evt_op[g*OP_W +: OP_W]),
            .en_ce   (cfg_q[B_EN_CE]),
            .en_nc   (cfg_q[B_EN_NC]),
            .en_fast (cfg_q[B_EN_FAST]),
            .req     (lane_req[g]),
            .hit     (lane_hit[g])
        );
    end

    always_comb begin
        req_any = '0;
        hit_any = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            req_any = req_any | lane_req[i];
            hit_any = hit_any | lane_hit[i];
        end
    end

    etr_status_reg sts_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (reg_wr && reg_addr),
        .clr_bits (reg_wdata[NUM_CLS-1:0]),
        .set_bits (hit_any),
        .sts_q    (sts_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trap_q <= '0;
        else        trap_q <= req_any;
    end

    always_comb begin
        trap_fast    = trap_q[T_FAST];
        trap_iacc    = trap_q[T_IACC];
        trap_dacc    = trap_q[T_DACC];
        trap_disr    = trap_q[T_DISR];
        frc_data_val = cfg_q[B_FD_LO +: FD_W];
        frc_data_vld = cfg_q[B_FD_VLD];
        frc_tag_val  = cfg_q[B_FT_LO +: FT_W];
        frc_tag_vld  = cfg_q[B_FT_VLD];
        reg_rdata    = reg_addr ? {{PAD_W{1'b0}}, sts_q} : cfg_q;
    end
endmodule

// File: rtl/err_trap_router_chk.sv
module err_trap_router_chk
    import etr_pkg::*;
#(
    parameter int NUM_LANES = 2,
    parameter int REG_W     = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_LANES-1:0]       evt_valid,
    input logic [CLS_W*NUM_LANES-1:0] evt_cls,
    input logic [OP_W*NUM_LANES-1:0]  evt_op,
    input logic                       reg_wr,
    input logic                       reg_addr,
    input logic [REG_W-1:0]           cfg_q,
    input logic [NUM_CLS-1:0]         sts_q,
    input logic                       trap_fast,
    input logic                       trap_iacc,
    input logic                       trap_dacc,
    input logic                       trap_disr
);
    logic all_late;
    logic [NUM_CLS-1:0] evt_oh;

    always_comb begin
        all_late = 1'b1;
        evt_oh   = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (evt_valid[i]) begin
                if (!(evt_op[i*OP_W +: OP_W] inside {3'd3, 3'd4, 3'd5})) all_late = 1'b0;
                if (evt_cls[i*CLS_W +: CLS_W] != 3'd7)
                    evt_oh = evt_oh | NUM_CLS'(1 << evt_cls[i*CLS_W +: CLS_W]);
            end
        end
    end

    AST_FAST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        trap_fast |-> $past(cfg_q[B_EN_FAST])); // R4
    AST_NO_FAST_LATE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        all_late |=> !trap_fast); // R5
    AST_ACC_NEEDS_NC: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_iacc || trap_dacc) |-> $past(cfg_q[B_EN_NC])); // R6
    AST_DISR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        trap_disr |-> $past(cfg_q[B_EN_CE] || cfg_q[B_EN_NC])); // R8
    AST_EVENT_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_oh) |=> ((sts_q & $past(evt_oh)) == $past(evt_oh))); // R9
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr) |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R10
    AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_fast || trap_iacc || trap_dacc || trap_disr) |-> $past(|evt_valid)); // R11
endmodule

bind err_trap_router err_trap_router_chk #(.NUM_LANES(NUM_LANES), .REG_W(REG_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_cls   (evt_cls),
    .evt_op    (evt_op),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .cfg_q     (cfg_q),
    .sts_q     (sts_q),
    .trap_fast (trap_fast),
    .trap_iacc (trap_iacc),
    .trap_dacc (trap_dacc),
    .trap_disr (trap_disr)
);

// File: tb/err_trap_router_tb_top.sv
module err_trap_router_tb_top;
    localparam int LANES = 2;
    localparam int RW    = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [LANES-1:0]   evt_valid = '0;
    logic [3*LANES-1:0] evt_cls = '0;
    logic [3*LANES-1:0] evt_op = '0;
    logic           reg_wr = 1'b0;
    logic           reg_addr = 1'b0;
    logic [RW-1:0]  reg_wdata = '0;
    logic [RW-1:0]  reg_rdata;
    logic           trap_fast, trap_iacc, trap_dacc, trap_disr;
    logic [8:0]     frc_data_val;
    logic           frc_data_vld;
    logic [3:0]     frc_tag_val;
    logic           frc_tag_vld;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    err_trap_router #(.NUM_LANES(LANES), .REG_W(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_cls(evt_cls),
        .evt_op(evt_op), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .trap_fast(trap_fast), .trap_iacc(trap_iacc), .trap_dacc(trap_dacc),
        .trap_disr(trap_disr), .frc_data_val(frc_data_val),
        .frc_data_vld(frc_data_vld), .frc_tag_val(frc_tag_val),
        .frc_tag_vld(frc_tag_vld)
    );

    // nibbles: class, op, enables {fast,nc,ce}, expected {fast,iacc,dacc,disr}
    localparam logic [15:0] VEC [10] = '{
        16'h0048, 16'h1370, 16'h2124, 16'h3222, 16'h4421,
        16'h5624, 16'h6511, 16'h6060, 16'h2050, 16'h1148
    };

    function automatic logic [3:0] ref_traps(input int c, input int o, input logic [2:0] en);
        logic [3:0] r = 4'b0;
        bit fetch = (o == 1) || (o == 6);
        bit ld    = (o == 0) || (o == 2);
        bit late  = (o >= 3) && (o <= 5);
        if ((c == 0 || c == 1) && en[2] && (fetch || ld)) r[3] = 1'b1;
        if (c >= 2 && c <= 5 && en[1]) begin
            r[2] = fetch; r[1] = ld; r[0] = late;
        end
        if (c == 6 && en[0]) r[0] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] en_word(input logic [2:0] en);
        return {28'b0, en[2], 1'b0, en[1], en[0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] traps();
        return {28'b0, trap_fast, trap_iacc, trap_dacc, trap_disr};
    endfunction

    task automatic wr_reg(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic one_event(input int c, input int o, input logic [2:0] en,
                             input logic [3:0] exp, input string req);
        wr_reg(1'b0, en_word(en));
        evt_valid = 2'b01; evt_cls = {3'd0, 3'(c)}; evt_op = {3'd0, 3'(o)};
        @(negedge clk);
        evt_valid = '0;
        check(req, traps(), {28'b0, exp});
        reg_addr = 1'b1;
        #0;
        check("R9 log", reg_rdata, (c == 7) ? 32'h0 : (32'h1 << c));
        @(negedge clk);
        check("R11 pulse end", traps(), 32'h0);
        wr_reg(1'b1, 32'h7F);
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cfg", reg_rdata, 32'h0);
        reg_addr = 1'b1; #1;
        check("R1 sts", reg_rdata, 32'h0);
        check("R1 traps", traps(), 32'h0);
        check("R1 force", {frc_tag_vld, frc_tag_val, frc_data_vld, frc_data_val}, 32'h0);
        rst_n = 1'b1;

        // R2 / R3 register layout and force outputs
        wr_reg(1'b0, 32'hFFFF_FFFF);
        reg_addr = 1'b0; #1;
        check("R2 mask", reg_rdata, 32'h0007_FFFB);
        wr_reg(1'b0, {13'b0, 1'b1, 4'hA, 1'b0, 9'h15A, 4'b0});
        reg_addr = 1'b0; #1;
        check("R3 data val", {23'b0, frc_data_val}, 32'h15A);
        check("R3 data vld", {31'b0, frc_data_vld}, 32'h0);
        check("R3 tag val", {28'b0, frc_tag_val}, 32'hA);
        check("R3 tag vld", {31'b0, frc_tag_vld}, 32'h1);

        // table of directed vectors (R4 R5 R6 R7 R8)
        foreach (VEC[i]) begin
            one_event(int'(VEC[i][14:12]), int'(VEC[i][10:8]), VEC[i][6:4], VEC[i][3:0],
                      "R4/R5/R6/R7/R8 table");
        end

        // full sweep against reference model
        for (int c = 0; c < 8; c++)
            for (int o = 0; o < 7; o++)
                for (int e = 0; e < 8; e++)
                    one_event(c, o, 3'(e), ref_traps(c, o, 3'(e)),
                              (o >= 3 && o <= 5) ? "R5 sweep" : (o == 6 ? "R7 sweep" : "R6 sweep"));

        // R11 two lanes in one cycle
        wr_reg(1'b0, en_word(3'b111));
        evt_valid = 2'b11; evt_cls = {3'd3, 3'd2}; evt_op = {3'd0, 3'd1};
        @(negedge clk);
        evt_valid = '0;
        check("R11 dual iacc+dacc", traps(), 32'h6);
        evt_valid = 2'b11; evt_cls = {3'd6, 3'd0}; evt_op = {3'd4, 3'd0};
        @(negedge clk);
        evt_valid = '0;
        check("R11 dual fast+disr", traps(), 32'h9);
        reg_addr = 1'b1; #1;
        check("R9 dual log", reg_rdata, 32'h4D);

        // R10 partial clear leaves other bits
        wr_reg(1'b1, 32'h05);
        reg_addr = 1'b1; #1;
        check("R10 partial clear", reg_rdata, 32'h48);
        // R10 clear colliding with new event: set wins
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 32'h7F;
        evt_valid = 2'b01; evt_cls = {3'd0, 3'd3}; evt_op = {3'd0, 3'd4};
        @(negedge clk);
        reg_wr = 1'b0; evt_valid = '0; #1;
        check("R10 set wins", reg_rdata, 32'h08);
        // R10 zero write changes nothing
        wr_reg(1'b1, 32'h0);
        reg_addr = 1'b1; #1;
        check("R10 zero write", reg_rdata, 32'h08);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule